// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block collects level-sensitive interrupt requests from sixteen external lines and from a software-interrupt register, and merges them into one pending vector. It then chooses the highest pending level that is above the processor's current interrupt level. When that choice yields a new trap type, it raises a single request toward the core.

Two timer-match bits in the software-interrupt register do not act as levels of their own. Either one forces level 14 pending. A request is held back when the core is already handling a trap of higher type at a nonzero trap level. While interrupts are globally disabled, the recorded state is frozen.

Evaluation is combinational on the inputs. The request flag and the recorded trap type are registers that change on the next rising clock edge.

Top module: `pil_resolver`

## Requirements
- R1: After a synchronous active-low reset, `irqReq` is 0 and `trapType` is 0.
- R2: The pending vector is `extLevels` ORed with `softInt[15:1]`, where `softInt[k]` stands for level k. `softInt[0]` and `softInt[16]` do not count at their own bit positions.
- R3: If tick match (`softInt[0]`) or system-tick match (`softInt[16]`) is set, level 14 is pending.
- R4: Only levels strictly above `procLevel` qualify, and the highest qualifying level is selected. Level 0 never qualifies.
- R5: The trap type for a selected level L is 0x40 ORed with L, so levels 1..15 give 0x41..0x4F.
- R6: When `trapLevel` is nonzero and `curTrapType` is greater than the candidate trap type, nothing changes on the next edge.
- R7: `trapType` is loaded with the candidate and `irqReq` is set to 1 only when the candidate differs from the recorded `trapType`. Otherwise both hold.
- R8: When `intEnable` is 0 and some level is pending, `irqReq` and `trapType` hold their values.
- R9: When no level is pending and `irqReq` is 1, `irqReq` goes to 0 and `trapType` goes to 0 on the next edge. With no level pending and `irqReq` at 0, both hold.
- R10: All updates happen on the rising clock edge after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| extLevels | input | 16 | External interrupt-level request lines, bit k = level k |
| softInt | input | 17 | Software-interrupt bits; bit 0 tick match, bit 16 system-tick match, bits 15..1 levels |
| procLevel | input | 4 | Current processor interrupt level |
| trapLevel | input | 3 | Current trap nesting level |
| curTrapType | input | 9 | Trap type currently being handled |
| intEnable | input | 1 | Global interrupt enable |
| irqReq | output | 1 | Interrupt request to the core |
| trapType | output | 9 | Recorded trap type of the request |

## Verification
Four rules are checked on every cycle: the clearing when nothing is pending, the freeze while disabled, the hold under trap-level suppression, and the load of a differing candidate. A further check confirms that an active request always carries a code in the 0x41..0x4F range. The bench scenarios are what show the merging of the pending vector itself. That covers the timer bits forcing level 14 and never counting at their own positions, and the choice of the highest level above `procLevel` when several levels compete. These cases are driven directly and also checked against a bench reference model under random stimulus.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam logic [8:0] EXT_INT_BASE = 9'h040;

  typedef struct packed {
    logic load;
    logic clear;
  } pil_strobe_t;
endpackage

// File: rtl/pil_datapath.sv
module pil_datapath
  import pil_pkg::*;
#(
  parameter int NUM_LEVELS  = 16,
  parameter int SOFT_WIDTH  = 17,
  parameter int TT_WIDTH    = 9,
  parameter int TICK_BIT    = 0,
  parameter int STICK_BIT   = 16,
  parameter int TIMER_LEVEL = 14,
  localparam int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] extLevels,
  input  logic [SOFT_WIDTH-1:0] softInt,
  input  logic [LVL_W-1:0]      procLevel,
  input  pil_strobe_t           stb,
  output logic                  anyPending,
  output logic                  candValid,
  output logic [TT_WIDTH-1:0]   candCode,
  output logic [TT_WIDTH-1:0]   trapType,
  output logic                  irqReq
);
  logic [SOFT_WIDTH-1:0] timerMask;
  logic [SOFT_WIDTH-1:0] softLevels;
  logic [NUM_LEVELS-1:0] pending;
  logic                  timerHit;
  logic [LVL_W-1:0]      winLevel;

  always_comb begin
    timerMask            = '0;
    timerMask[TICK_BIT]  = 1'b1;
    timerMask[STICK_BIT] = 1'b1;
    softLevels = softInt & ~timerMask;
    timerHit   = softInt[TICK_BIT] | softInt[STICK_BIT];
    pending    = extLevels | softLevels[NUM_LEVELS-1:0];
    if (timerHit) pending[TIMER_LEVEL] = 1'b1;
    anyPending = |pending;
  end

  // ascending scan: the last hit, i.e. the highest level, wins
  always_comb begin
    candValid = 1'b0;
    winLevel  = '0;
    for (int i = 1; i < NUM_LEVELS; i++) begin
      if (pending[i] && (LVL_W'(i) > procLevel)) begin
        candValid = 1'b1;
        winLevel  = LVL_W'(i);
      end
    end
    candCode = TT_WIDTH'(EXT_INT_BASE) | TT_WIDTH'(winLevel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trapType <= '0;
      irqReq   <= 1'b0;
    end else if (stb.clear) begin
      trapType <= '0;
      irqReq   <= 1'b0;
    end else if (stb.load) begin
      trapType <= candCode;
      irqReq   <= 1'b1;
    end
  end

  p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (trapType[TT_WIDTH-1:LVL_W] == TT_WIDTH'(EXT_INT_BASE) >> LVL_W)
               && (trapType[LVL_W-1:0] != '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyPending && irqReq) |=> (!irqReq && trapType == '0));
endmodule

// File: rtl/pil_control.sv
module pil_control
  import pil_pkg::*;
#(
  parameter int TT_WIDTH  = 9,
  parameter int TL_WIDTH  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                intEnable,
  input  logic [TL_WIDTH-1:0] trapLevel,
  input  logic [TT_WIDTH-1:0] curTrapType,
  input  logic                anyPending,
  input  logic                candValid,
  input  logic [TT_WIDTH-1:0] candCode,
  input  logic [TT_WIDTH-1:0] trapType,
  input  logic                irqReq,
  output pil_strobe_t         stb
);
  logic suppress;

  always_comb begin
    suppress  = (trapLevel != '0) && (curTrapType > candCode);
    stb.clear = !anyPending && irqReq;
    stb.load  = anyPending && intEnable && candValid && !suppress
                && (candCode != trapType);
  end

  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!intEnable && anyPending) |=> $stable(trapType) && $stable(irqReq));

  p_suppress_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (anyPending && trapLevel != '0 && candValid && curTrapType > candCode)
      |=> $stable(trapType) && $stable(irqReq));

  p_load_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (anyPending && intEnable && candValid && !(trapLevel != '0 && curTrapType > candCode)
     && candCode != trapType) |=> (irqReq && trapType == $past(candCode)));
endmodule

// File: rtl/pil_resolver.sv
module pil_resolver
  import pil_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int SOFT_WIDTH = 17,
  parameter int TT_WIDTH   = 9,
  parameter int TL_WIDTH   = 3,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] extLevels,
  input  logic [SOFT_WIDTH-1:0] softInt,
  input  logic [LVL_W-1:0]      procLevel,
  input  logic [TL_WIDTH-1:0]   trapLevel,
  input  logic [TT_WIDTH-1:0]   curTrapType,
  input  logic                  intEnable,
  output logic                  irqReq,
  output logic [TT_WIDTH-1:0]   trapType
);
  pil_strobe_t         stb;
  logic                anyPending;
  logic                candValid;
  logic [TT_WIDTH-1:0] candCode;

  pil_datapath #(
    .NUM_LEVELS(NUM_LEVELS), .SOFT_WIDTH(SOFT_WIDTH), .TT_WIDTH(TT_WIDTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .extLevels(extLevels), .softInt(softInt),
    .procLevel(procLevel), .stb(stb), .anyPending(anyPending),
    .candValid(candValid), .candCode(candCode), .trapType(trapType),
    .irqReq(irqReq)
  );

  pil_control #(.TT_WIDTH(TT_WIDTH), .TL_WIDTH(TL_WIDTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .intEnable(intEnable), .trapLevel(trapLevel),
    .curTrapType(curTrapType), .anyPending(anyPending), .candValid(candValid),
    .candCode(candCode), .trapType(trapType), .irqReq(irqReq), .stb(stb)
  );
endmodule

// File: tb/tb_pil_resolver.sv
`timescale 1ns/1ps
module tb_pil_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] extLevels;
  logic [16:0] softInt;
  logic [3:0]  procLevel;
  logic [2:0]  trapLevel;
  logic [8:0]  curTrapType;
  logic        intEnable;
  logic        irqReq;
  logic [8:0]  trapType;

  int checks = 0;
  int fails  = 0;
  logic       expReq;
  logic [8:0] expTt;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pil_resolver dut (
    .clk(clk), .rst_n(rst_n), .extLevels(extLevels), .softInt(softInt),
    .procLevel(procLevel), .trapLevel(trapLevel), .curTrapType(curTrapType),
    .intEnable(intEnable), .irqReq(irqReq), .trapType(trapType)
  );

  function automatic logic [15:0] refPending(logic [15:0] e, logic [16:0] s);
    logic [15:0] p;
    p = e | {s[15:1], 1'b0};
    if (s[0] || s[16]) p[14] = 1'b1;
    return p;
  endfunction

  function automatic int refPick(logic [15:0] p, logic [3:0] pl);
    for (int i = 15; i > int'(pl); i--)
      if (p[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag);
    checks++;
    if (irqReq !== expReq || trapType !== expTt) begin
      fails++;
      $display("FAIL %s: irqReq=%0b trapType=%h expected irqReq=%0b trapType=%h",
               tag, irqReq, trapType, expReq, expTt);
    end
  endtask

  // called at a falling edge with inputs set; advances one cycle and checks
  task automatic step(string forceTag);
    logic [15:0] p;
    int lvl;
    logic [8:0] cand;
    string tag;
    p = refPending(extLevels, softInt);
    lvl = refPick(p, procLevel);
    tag = "R7";
    if (p == 16'h0) begin
      tag = "R9";
      if (expReq) begin expReq = 1'b0; expTt = 9'h0; end
    end else if (!intEnable) begin
      tag = "R8";
    end else if (lvl >= 0) begin
      cand = 9'h040 | 9'(lvl);
      if (trapLevel != 0 && curTrapType > cand) tag = "R6";
      else if (cand != expTt) begin
        tag = "R4"; expTt = cand; expReq = 1'b1;
      end
    end
    if (forceTag != "") tag = forceTag;
    @(posedge clk); #5;
    check(tag);
    @(negedge clk);
  endtask

  task automatic setIn(logic [15:0] e, logic [16:0] s, logic [3:0] pl,
                       logic [2:0] tl, logic [8:0] ct, logic en);
    extLevels = e; softInt = s; procLevel = pl;
    trapLevel = tl; curTrapType = ct; intEnable = en;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    setIn(16'hFFFF, 17'h1FFFF, 4'd0, 3'd0, 9'h0, 1'b1);
    expReq = 1'b0; expTt = 9'h0;
    @(negedge clk); @(negedge clk);
    @(posedge clk); #5;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    setIn(16'h0, 17'h0, 4'd0, 3'd0, 9'h0, 1'b1);
    step("R1");

    // R2: soft bit 5 is level 5
    setIn(16'h0, 17'h00020, 4'd0, 3'd0, 9'h0, 1'b1);
    step("R2");
    if (trapType != 9'h045) $display("FAIL R2: trapType=%h expected 045", trapType);
    // R9: clear when nothing pending
    setIn(16'h0, 17'h0, 4'd0, 3'd0, 9'h0, 1'b1);
    step("R9");
    // R3: system-tick bit alone forces 0x4E
    setIn(16'h0, 17'h10000, 4'd0, 3'd0, 9'h0, 1'b1);
    step("R3");
    setIn(16'h0, 17'h0, 4'd0, 3'd0, 9'h0, 1'b1);
    step("R9");
    // R3: tick bit alone forces 0x4E
    setIn(16'h0, 17'h00001, 4'd3, 3'd0, 9'h0, 1'b1);
    step("R3");
    // R2: timer bits at procLevel 14 give nothing new (level 14 not above 14)
    setIn(16'h0, 17'h0, 4'd0, 3'd0, 9'h0, 1'b1);
    step("R9");
    setIn(16'h0, 17'h10001, 4'd14, 3'd0, 9'h0, 1'b1);
    step("R2");
    // R4/R5: levels 3 and 9 with procLevel 5 -> 0x49
    setIn(16'h0208, 17'h0, 4'd5, 3'd0, 9'h0, 1'b1);
    step("R5");
    // R4: levels 3 and 9 with procLevel 9 -> none qualify, hold
    setIn(16'h0208, 17'h0, 4'd9, 3'd0, 9'h0, 1'b1);
    step("R4");
    // R7: same candidate again holds
    setIn(16'h0208, 17'h0, 4'd5, 3'd0, 9'h0, 1'b1);
    step("R7");
    // R6: higher trap in progress suppresses level 15
    setIn(16'h8000, 17'h0, 4'd0, 3'd2, 9'h050, 1'b1);
    step("R6");
    // R6: lower trap in progress does not suppress
    setIn(16'h8000, 17'h0, 4'd0, 3'd2, 9'h041, 1'b1);
    step("R6");
    // R8: disabled freezes
    setIn(16'h0004, 17'h0, 4'd0, 3'd0, 9'h0, 1'b0);
    step("R8");
    // R10 random
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] e;
      logic [16:0] s;
      e = ($urandom % 3 == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
      s = ($urandom % 3 == 0) ? 17'(1 << ($urandom % 17)) : 17'h0;
      setIn(e, s, 4'($urandom), ($urandom % 4 == 0) ? 3'($urandom) : 3'd0,
            9'h040 | 9'($urandom % 16), ($urandom % 6) != 0);
      step("");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule